// File: doc/BRIEF.md
# Receive Cell Buffer with Interrupt Register

This block sits on the receive side of a cell-based link. It stores fixed-size cells from a cell processor and hands them out to an ATM-layer reader over a UTOPIA-style byte interface. The writer marks the first byte of every cell with a start-of-cell strobe. The buffer commits a cell only after all of its bytes have arrived. A cell that is cut short by a new start-of-cell is thrown away and reported as a change of cell alignment. The reader sees a cell-available flag that is high only while at least one complete cell is stored, and it pulls bytes one per cycle with a read enable.

Three fault causes are tracked: a runt cell, a read attempt with no complete cell stored (underrun), and a new cell arriving while every slot is occupied (overrun; the oldest stored cell is overwritten). Each cause sets a sticky status bit in one 8-bit register on a small microprocessor bus. A read of that register returns the status and then clears it. Each cause has its own enable bit, and an active-low interrupt output is driven low while any enabled status bit is set. A self-clearing bit in the same register flushes the buffer.

The enable bits have no defined value after reset that software may rely on, so they must be programmed before the interrupt output is used.

Top module: `rx_cell_buf`

## Requirements
- R1: After reset, cell_avail is 0, rd_valid is 0, int_n is 1, and a register read returns 0 in bit 7, bit 6 and status bits 2..0.
- R2: A cell of 53 bytes that starts with wr_soc is stored and cell_avail goes high on the edge that takes its last byte. Reading it returns the same 53 bytes in order, each on rd_data with rd_valid high one cycle after its rd_en cycle.
- R3: Up to 4 complete cells are held and read out in arrival order. cell_avail drops on the edge that takes the last byte of the last stored cell.
- R4: A wr_soc that arrives before the current cell has 53 bytes discards the partial cell, sets status bit 0 (alignment change), and starts a new cell with that byte.
- R5: Bytes with wr_valid high and no cell open (no wr_soc seen since the last cell completed) are ignored: they are never read out and they set no status bit.
- R6: rd_en while no complete cell is stored sets status bit 1 (underrun), and rd_valid stays 0 on the following cycle.
- R7: A wr_soc while 4 cells are stored sets status bit 2 (overrun) and drops the oldest stored cell. The new cell takes its place, so the reader then gets the three newer cells and the new one.
- R8: The register answers at address 0x6B. cpu_rdata is valid one cycle after cpu_rd and holds bit 7 = 0, bit 6 = flush bit, bits 5/4/3 = overrun/underrun/alignment enables, bits 2/1/0 = overrun/underrun/alignment status. A read at any other address returns 0 and clears nothing.
- R9: A read of the register clears status bits 2..0 after returning them. If a status event happens in the same cycle as the read, the event wins and the bit stays set.
- R10: int_n is low exactly while some status bit and its matching enable are both 1. It follows on the same edge that changes the status or enable. Writes to bits 2..0 do not change the status.
- R11: Writing 1 to bit 6 sets the flush bit for one cycle. On the following edge every stored and partial cell is discarded and cell_avail is 0. The bit clears itself, and status and enables are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Writer byte strobe |
| wr_soc | input | 1 | Marks the first byte of a cell |
| wr_data | input | 8 | Writer byte |
| rd_en | input | 1 | Reader pulls one byte |
| rd_data | output | 8 | Byte returned to the reader |
| rd_valid | output | 1 | rd_data holds a byte from the previous rd_en |
| cell_avail | output | 1 | At least one complete cell is stored |
| cpu_addr | input | 8 | Register bus address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, one cycle after cpu_rd |
| int_n | output | 1 | Active-low interrupt |

## Verification
Whole cells are streamed through singly, back to back up to four, and with a fifth arriving while the buffer is full. These runs separate correct ordering from slot-address mistakes and show whether overrun drops the oldest cell rather than the newest. Truncated cells followed by a full cell, stray bytes with no start strobe, and reads of an empty buffer tell the runt, ignore and underrun paths apart. Status reads made in the same cycle as an event, reads at a neighbouring address, enable masking, and a flush with cells stored pin down the register's clear-on-read, interrupt gating and self-clearing flush.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  // status / event cause order, matches register bits 2..0
  typedef struct packed {
    logic ovf;
    logic unf;
    logic aln;
  } evt_t;

  localparam int REG_FLUSH_BIT = 6;
  localparam int REG_EN_LSB    = 3;
  localparam int CAUSES        = 3;
endpackage

// File: rtl/rcb_cell_ram.sv
module rcb_cell_ram #(
  parameter int DW    = 8,
  parameter int WORDS = 212,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rcb_ptr_ctrl.sv
module rcb_ptr_ctrl
  import rcb_pkg::*;
#(
  parameter int CELL_BYTES  = 53,
  parameter int DEPTH_CELLS = 4,
  parameter int AW          = 8,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_valid,
  input  logic             wr_soc,
  input  logic             rd_en,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic             ram_re,
  output logic [AW-1:0]    ram_raddr,
  output logic             rd_valid,
  output logic             cell_avail,
  output logic [CNT_W-1:0] cnt,
  output evt_t             evt
);
  localparam int SLOT_W = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int OFF_W  = $clog2(CELL_BYTES);
  localparam logic [OFF_W-1:0]  LAST_OFF  = OFF_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH_CELLS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH_CELLS);

  logic [SLOT_W-1:0] wslot, rslot;
  logic [OFF_W-1:0]  woff, roff;
  logic              wopen;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              soc_acc, byte_acc, commit, release_c, drop, advance;

  function automatic logic [AW-1:0] cell_addr(input logic [SLOT_W-1:0] s,
                                              input logic [OFF_W-1:0] o);
    return AW'(s) * AW'(CELL_BYTES) + AW'(o);
  endfunction

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (s == LAST_SLOT) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    soc_acc   = !flush && wr_valid && wr_soc;
    byte_acc  = !flush && wr_valid && !wr_soc && wopen;
    commit    = byte_acc && (woff == LAST_OFF);
    drop      = soc_acc && (cnt_q == FULL_CNT);
    ram_we    = soc_acc || byte_acc;
    ram_waddr = cell_addr(wslot, soc_acc ? '0 : woff);
    ram_re    = !flush && rd_en && (cnt_q != '0);
    ram_raddr = cell_addr(rslot, roff);
    release_c = ram_re && (roff == LAST_OFF);
    advance   = drop || release_c;
    cnt_d     = cnt_q + CNT_W'(commit) - CNT_W'(advance);
    evt.aln   = soc_acc && wopen;
    evt.unf   = !flush && rd_en && (cnt_q == '0);
    evt.ovf   = drop;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wslot      <= '0;
      woff       <= '0;
      wopen      <= 1'b0;
      rslot      <= '0;
      roff       <= '0;
      cnt_q      <= '0;
      cell_avail <= 1'b0;
      rd_valid   <= 1'b0;
    end else begin
      if (soc_acc) begin
        woff  <= OFF_W'(1);
        wopen <= 1'b1;
      end else if (byte_acc) begin
        if (commit) begin
          woff  <= '0;
          wopen <= 1'b0;
          wslot <= next_slot(wslot);
        end else begin
          woff <= woff + 1'b1;
        end
      end
      if (advance) begin
        rslot <= next_slot(rslot);
        roff  <= '0;
      end else if (ram_re) begin
        roff <= roff + 1'b1;
      end
      cnt_q      <= cnt_d;
      cell_avail <= (cnt_d != '0);
      rd_valid   <= ram_re;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rcb_irq_regs.sv
module rcb_irq_regs
  import rcb_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h6B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  input  evt_t              evt,
  output logic [7:0]        cpu_rdata,
  output logic              int_n,
  output logic              flush,
  output logic [CAUSES-1:0] status,
  output logic [CAUSES-1:0] enable
);
  logic              hit, rd_hit, wr_hit;
  logic [CAUSES-1:0] st_q, st_d, en_q, en_d;
  logic              flush_q;

  always_comb begin
    hit    = (cpu_addr == ADDR_W'(REG_ADDR));
    rd_hit = cpu_rd && hit;
    wr_hit = cpu_wr && hit;
    st_d   = (rd_hit ? '0 : st_q) | evt;
    en_d   = wr_hit ? cpu_wdata[REG_EN_LSB +: CAUSES] : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= '0;
      en_q      <= '0;
      flush_q   <= 1'b0;
      cpu_rdata <= '0;
      int_n     <= 1'b1;
    end else begin
      st_q      <= st_d;
      en_q      <= en_d;
      flush_q   <= wr_hit && cpu_wdata[REG_FLUSH_BIT];
      cpu_rdata <= rd_hit ? {1'b0, flush_q, en_q, st_q} : '0;
      int_n     <= ~|(st_d & en_d);
    end
  end

  assign flush  = flush_q;
  assign status = st_q;
  assign enable = en_q;
endmodule

// File: rtl/rx_cell_buf.sv
module rx_cell_buf
  import rcb_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         CELL_BYTES  = 53,
  parameter int         DEPTH_CELLS = 4,
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] REG_ADDR    = 8'h6B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_soc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              cell_avail,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              int_n
);
  localparam int WORDS = CELL_BYTES * DEPTH_CELLS;
  localparam int MEM_AW = $clog2(WORDS);
  localparam int CNT_W  = $clog2(DEPTH_CELLS + 1);

  logic              ram_we, ram_re, flush_w;
  logic [MEM_AW-1:0] ram_waddr, ram_raddr;
  logic [CNT_W-1:0]  cnt_w;
  logic [CAUSES-1:0] status_w, enable_w;
  evt_t              evt_w;

  rcb_ptr_ctrl #(
    .CELL_BYTES(CELL_BYTES), .DEPTH_CELLS(DEPTH_CELLS),
    .AW(MEM_AW), .CNT_W(CNT_W)
  ) u_ptr (
    .clk(clk), .rst(rst), .flush(flush_w),
    .wr_valid(wr_valid), .wr_soc(wr_soc), .rd_en(rd_en),
    .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_re(ram_re), .ram_raddr(ram_raddr),
    .rd_valid(rd_valid), .cell_avail(cell_avail),
    .cnt(cnt_w), .evt(evt_w)
  );

  rcb_cell_ram #(.DW(DATA_W), .WORDS(WORDS), .AW(MEM_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(rd_data)
  );

  rcb_irq_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .evt(evt_w),
    .cpu_rdata(cpu_rdata), .int_n(int_n), .flush(flush_w),
    .status(status_w), .enable(enable_w)
  );
endmodule

// File: rtl/rcb_checker.sv
module rcb_checker #(
  parameter int DEPTH_CELLS = 4,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             int_n,
  input logic             cell_avail,
  input logic             rd_valid,
  input logic [7:0]       cpu_rdata,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       status,
  input logic [2:0]       enable,
  input logic             flush
);
  a_r10_int_gating: assert property (@(posedge clk) disable iff (rst)
    int_n == !(|(status & enable)));

  a_r2_avail_tracks_count: assert property (@(posedge clk) disable iff (rst)
    cell_avail == (cnt != '0));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH_CELLS));

  a_r6_no_data_when_empty: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cell_avail));

  a_r8_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[7] == 1'b0);

  a_r11_flush_self_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0) && !cell_avail);
endmodule

bind rx_cell_buf rcb_checker #(.DEPTH_CELLS(DEPTH_CELLS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .int_n(int_n), .cell_avail(cell_avail),
  .rd_valid(rd_valid), .cpu_rdata(cpu_rdata), .cnt(cnt_w),
  .status(status_w), .enable(enable_w), .flush(flush_w)
);

// File: tb/rx_cell_buf_tb.sv
`timescale 1ns/1ps
module rx_cell_buf_tb_top;
  localparam int CELL = 53;
  localparam logic [7:0] RA = 8'h6B;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 0, wr_soc = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       rd_valid, cell_avail;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic       cpu_wr = 0, cpu_rd = 0;
  logic       int_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  rx_cell_buf dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_soc(wr_soc),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .cell_avail(cell_avail), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .int_n(int_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: R2 R3 data order
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2/R3 unexpected byte: actual=%0h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL R2/R3 data: actual=%0h expected=%0h", rd_data, e);
        end
      end
    end
  end

  task automatic send_bytes(input logic [7:0] base, input int n, input bit soc, input bit track);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_soc   = soc && (i == 0);
      wr_data  = base + 8'(i);
      if (track) exp_q.push_back(base + 8'(i));
      @(negedge clk);
    end
    wr_valid = 1'b0;
    wr_soc   = 1'b0;
  endtask

  task automatic read_cell();
    for (int i = 0; i < CELL; i++) begin
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
    cpu_addr = a;
    cpu_rd   = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    cpu_addr  = RA;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cell_avail", cell_avail, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 int_n", int_n, 1);
    cpu_read(RA, r);
    chk("R1 reg fixed bits", r & 8'hC7, 0);

    // R8 enables readback
    cpu_write(8'h38);
    cpu_read(RA, r);
    chk("R8 enable readback", r, 8'h38);

    // R2 single cell
    send_bytes(8'h10, CELL, 1, 1);
    chk("R2 cell_avail after last byte", cell_avail, 1);
    read_cell();
    chk("R3 cell_avail after drain", cell_avail, 0);

    // R3 three cells in order
    send_bytes(8'h40, CELL, 1, 1);
    send_bytes(8'h80, CELL, 1, 1);
    send_bytes(8'hC0, CELL, 1, 1);
    repeat (3) read_cell();
    chk("R3 empty after three", cell_avail, 0);

    // R5 stray bytes ignored
    send_bytes(8'hEE, 10, 0, 0);
    chk("R5 no cell from stray", cell_avail, 0);
    send_bytes(8'h20, CELL, 1, 1);
    read_cell();
    cpu_read(RA, r);
    chk("R5 no status from stray", r, 8'h38);
    chk("R5 int_n idle", int_n, 1);

    // R4 runt, R10 interrupt, R8 other address, R9 clear
    send_bytes(8'h99, 20, 1, 0);
    send_bytes(8'h30, CELL, 1, 1);
    chk("R10 int_n low on runt", int_n, 0);
    cpu_read(8'h6A, r);
    chk("R8 other address reads 0", r, 0);
    cpu_read(RA, r);
    chk("R4 alignment status", r, 8'h39);
    chk("R9 int_n released after read", int_n, 1);
    cpu_read(RA, r);
    chk("R9 status cleared", r, 8'h38);
    read_cell();

    // R6 underrun
    pulse_rd();
    chk("R6 no rd_valid when empty", rd_valid, 0);
    cpu_read(RA, r);
    chk("R6 underrun status", r, 8'h3A);

    // R7 overrun drops oldest
    send_bytes(8'h01, CELL, 1, 1);
    send_bytes(8'h41, CELL, 1, 1);
    send_bytes(8'h81, CELL, 1, 1);
    send_bytes(8'hC1, CELL, 1, 1);
    repeat (CELL) void'(exp_q.pop_front());
    send_bytes(8'h61, CELL, 1, 1);
    cpu_read(RA, r);
    chk("R7 overrun status", r, 8'h3C);
    repeat (4) read_cell();
    chk("R7 empty after four", cell_avail, 0);

    // R10 enable gating
    cpu_write(8'h00);
    pulse_rd();
    chk("R10 masked int_n", int_n, 1);
    cpu_write(8'h10);
    chk("R10 int_n after enable", int_n, 0);
    cpu_read(RA, r);
    chk("R10 reg with unf", r, 8'h12);
    chk("R10 int_n after clear", int_n, 1);
    cpu_write(8'h07);
    cpu_read(RA, r);
    chk("R10 status not writable", r, 8'h00);

    // R9 event in same cycle as read
    rd_en = 1'b1;
    cpu_addr = RA;
    cpu_rd = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    cpu_rd = 1'b0;
    chk("R9 read before event", cpu_rdata, 8'h00);
    cpu_read(RA, r);
    chk("R9 event wins", r, 8'h02);

    // R11 flush
    cpu_write(8'h38);
    pulse_rd();
    send_bytes(8'h11, CELL, 1, 1);
    send_bytes(8'h51, CELL, 1, 1);
    send_bytes(8'h77, 7, 1, 0);
    cpu_write(8'h78);
    @(negedge clk);
    chk("R11 flush empties", cell_avail, 0);
    exp_q.delete();
    cpu_read(RA, r);
    chk("R11 bit self-clears, status kept", r, 8'h3A);
    send_bytes(8'h23, CELL, 1, 1);
    chk("R11 clean after flush", cell_avail, 1);
    read_cell();
    chk("R3 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule